// File: doc/BRIEF.md
# Accumulator Arithmetic Execute Unit

This unit decodes one opcode per clock from the byte-oriented accumulator architecture's arithmetic group and computes its result: add, add with carry, subtract with borrow, increment and decrement. Operands come from the accumulator, from an eight-entry working register bank, from internal data memory (addressed by a second instruction byte or through working register 0 or 1), or from an immediate second byte. The unit also steps the 16-bit data pointer.

Operand reads are combinational. In the cycle an opcode is presented with `issue_i` high, the unit drives a register-bank index and a data-memory address and takes the returned bytes in that same cycle. On the next clock edge it registers the outcome: a completion pulse, an illegal-opcode flag, the instruction length in bytes, the cycle count a fast core spends on the opcode, an optional write-back to the register bank or data memory, and the updated accumulator, carry (CY), auxiliary carry (AC), overflow (OV) and data pointer. A sequencer uses length and cycle count to advance the fetch and to pace the pipeline.

Top module: `arith_exec_unit`

## Requirements
- R1: Addition opcodes: 28h–2Fh add working register n (n = opcode bits 2:0), 25h adds the data-memory byte at the address in the second byte, 26h/27h add the data-memory byte addressed by working register 0/1 (opcode bit 0), 24h adds the second byte. The 8-bit sum replaces the accumulator.
- R2: 38h–3Fh, 35h, 36h–37h and 34h use the same operand forms as R1 and also add the carry flag into the sum.
- R3: 98h–9Fh, 95h, 96h–97h and 94h use the same operand forms and set the accumulator to accumulator minus operand minus carry, modulo 256.
- R4: The opcodes of R1–R3 set CY to the carry (or borrow) out of bit 7, AC to the carry (or borrow) out of bit 3, and OV when the signed two's-complement result lies outside -128..127.
- R5: Increment opcodes 04h (accumulator), 08h–0Fh (register n), 05h (direct byte) and 06h–07h (byte at @R0/@R1), and decrement opcodes 14h, 18h–1Fh, 15h, 16h–17h, change the target by +1/-1 modulo 256. A register target gives write-back with `wb_to_mem_o`=0 and `wb_addr_o`=n; a memory target gives `wb_to_mem_o`=1 and the memory address. CY, AC and OV and, for non-accumulator targets, the accumulator are unchanged.
- R6: Opcode A3h adds one to the 16-bit data pointer, carrying from the low byte into the high byte; FFFFh becomes 0000h. It writes back nothing and changes no flag.
- R7: `len_o` is 2 for the direct (x5h) and immediate (x4h of the R1–R3 groups) forms and 1 for all other legal opcodes.
- R8: `cyc_o` is 1 for the register, accumulator and data-pointer forms and 2 for the direct, indirect and immediate forms.
- R9: Any other opcode gives `done_o`=1, `illegal_o`=1, `len_o`=1, `cyc_o`=1, no write-back, and leaves accumulator, flags and data pointer unchanged.
- R10: While an opcode is issued, `rf_addr_o` carries n for register forms and 0/1 for indirect forms; `mem_addr_o` carries the second byte for direct forms and the value read from the pointer register for indirect forms.
- R11: After reset the accumulator, flags and data pointer are zero and every result output is zero.
- R12: A cycle with `issue_i` low leaves `done_o`, `illegal_o`, `len_o`, `cyc_o`, `wb_en_o`, `wb_to_mem_o`, `wb_addr_o` and `wb_data_o` zero in the following cycle and holds the accumulator, flags and data pointer. The write-back fields are also zero for legal opcodes that write back nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Opcode and second byte are valid this cycle |
| opcode_i | input | 8 | Opcode byte |
| imm_i | input | 8 | Second instruction byte (direct address or immediate data) |
| rf_addr_o | output | 3 | Working register bank read index |
| rf_data_i | input | 8 | Working register read data |
| mem_addr_o | output | 8 | Internal data memory read address |
| mem_data_i | input | 8 | Internal data memory read data |
| done_o | output | 1 | One instruction completed in the previous cycle |
| illegal_o | output | 1 | Completed opcode was not recognized |
| len_o | output | 2 | Instruction length in bytes |
| cyc_o | output | 2 | Instruction cycle count |
| wb_en_o | output | 1 | Write-back valid |
| wb_to_mem_o | output | 1 | Write-back targets data memory (1) or register bank (0) |
| wb_addr_o | output | 8 | Write-back register index or memory address |
| wb_data_o | output | 8 | Write-back byte |
| acc_o | output | 8 | Accumulator |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary carry flag |
| ov_o | output | 1 | Overflow flag |
| dptr_o | output | 16 | Data pointer |

## Verification
The hardest state to reach from the ports is the data pointer rolling over from FFFFh, because nothing but the one-step increment moves it. The stimulus issues that opcode back to back for more than 65536 cycles so the carry ripples through the high byte and the wrap to zero is seen. Signed overflow and half-carry corner cases need the accumulator at chosen values first, so directed sequences of immediate additions and subtractions set it up before each operand form is tried, and a long random run covers the whole opcode space, illegal codes included.

// File: rtl/arith_exec_pkg.sv
package arith_exec_pkg;

    typedef enum logic [2:0] {
        K_ADD,
        K_ADDC,
        K_SUBB,
        K_INC,
        K_DEC,
        K_PTRINC,
        K_NONE
    } op_kind_e;

    typedef enum logic [2:0] {
        S_NONE,
        S_ACC,
        S_REG,
        S_DIR,
        S_IND,
        S_IMM
    } op_src_e;

    typedef struct packed {
        logic     legal;
        op_kind_e kind;
        op_src_e  src;
        logic [1:0] len;
        logic [1:0] cyc;
    } dec_t;

endpackage

// File: rtl/arith_decode.sv
module arith_decode
    import arith_exec_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    logic [3:0] hi_nib;
    logic [3:0] lo_nib;
    logic       grp_arith;
    logic       grp_step;

    assign hi_nib = opcode[7:4];
    assign lo_nib = opcode[3:0];

    always_comb begin
        grp_arith = 1'b0;
        grp_step  = 1'b0;
        dec.legal = 1'b0;
        dec.kind  = K_NONE;
        dec.src   = S_NONE;
        unique case (hi_nib)
            4'h2: begin grp_arith = 1'b1; dec.kind = K_ADD;  end
            4'h3: begin grp_arith = 1'b1; dec.kind = K_ADDC; end
            4'h9: begin grp_arith = 1'b1; dec.kind = K_SUBB; end
            4'h0: begin grp_step  = 1'b1; dec.kind = K_INC;  end
            4'h1: begin grp_step  = 1'b1; dec.kind = K_DEC;  end
            default: dec.kind = K_NONE;
        endcase

        if (grp_arith || grp_step) begin
            if (lo_nib[3]) begin
                dec.src   = S_REG;
                dec.legal = 1'b1;
            end else if (lo_nib[2]) begin
                dec.legal = 1'b1;
                unique case (lo_nib[1:0])
                    2'b00:   dec.src = grp_arith ? S_IMM : S_ACC;
                    2'b01:   dec.src = S_DIR;
                    default: dec.src = S_IND;
                endcase
            end
        end

        if (opcode == 8'hA3) begin
            dec.legal = 1'b1;
            dec.kind  = K_PTRINC;
            dec.src   = S_NONE;
        end

        if (!dec.legal) begin
            dec.kind = K_NONE;
            dec.src  = S_NONE;
        end

        dec.len = ((dec.src == S_DIR) || (dec.src == S_IMM)) ? 2'd2 : 2'd1;
        dec.cyc = ((dec.src == S_DIR) || (dec.src == S_IMM) || (dec.src == S_IND)) ? 2'd2 : 2'd1;
    end
endmodule

// File: rtl/arith_alu.sv
module arith_alu #(
    parameter int DATA_W = 8
) (
    input  logic              sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cy,
    output logic              ac,
    output logic              ov
);
    localparam int LO_W  = DATA_W / 2;
    localparam int MID_W = DATA_W - 1 - LO_W;

    logic [DATA_W-1:0] b_eff;
    logic              c_eff;
    logic [LO_W:0]     lo_sum;
    logic [MID_W:0]    mid_sum;
    logic [1:0]        top_sum;

    // Subtraction as a + ~b + ~cin; borrows are the inverted carries.
    assign b_eff = sub ? ~b : b;
    assign c_eff = sub ? ~cin : cin;

    always_comb begin
        lo_sum  = {1'b0, a[LO_W-1:0]} + {1'b0, b_eff[LO_W-1:0]} + {{LO_W{1'b0}}, c_eff};
        mid_sum = {1'b0, a[DATA_W-2:LO_W]} + {1'b0, b_eff[DATA_W-2:LO_W]}
                + {{MID_W{1'b0}}, lo_sum[LO_W]};
        top_sum = {1'b0, a[DATA_W-1]} + {1'b0, b_eff[DATA_W-1]} + {1'b0, mid_sum[MID_W]};
        res     = {top_sum[0], mid_sum[MID_W-1:0], lo_sum[LO_W-1:0]};
        cy      = top_sum[1] ^ sub;
        ac      = lo_sum[LO_W] ^ sub;
        ov      = top_sum[1] ^ mid_sum[MID_W];
    end
endmodule

// File: rtl/ptr_incr.sv
module ptr_incr #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 16
) (
    input  logic [PTR_W-1:0] ptr_in,
    output logic [PTR_W-1:0] ptr_out
);
    localparam int NBYTES = PTR_W / DATA_W;

    logic [NBYTES:0] carry;
    assign carry[0] = 1'b1;

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
        logic [DATA_W:0] lane;
        assign lane = {1'b0, ptr_in[gi*DATA_W +: DATA_W]} + {{DATA_W{1'b0}}, carry[gi]};
        assign ptr_out[gi*DATA_W +: DATA_W] = lane[DATA_W-1:0];
        assign carry[gi+1] = lane[DATA_W];
    end
endmodule

// File: rtl/arith_exec_unit.sv
module arith_exec_unit
    import arith_exec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RF_AW  = 3,
    parameter int PTR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [7:0]        opcode_i,
    input  logic [DATA_W-1:0] imm_i,
    output logic [RF_AW-1:0]  rf_addr_o,
    input  logic [DATA_W-1:0] rf_data_i,
    output logic [DATA_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              done_o,
    output logic              illegal_o,
    output logic [1:0]        len_o,
    output logic [1:0]        cyc_o,
    output logic              wb_en_o,
    output logic              wb_to_mem_o,
    output logic [DATA_W-1:0] wb_addr_o,
    output logic [DATA_W-1:0] wb_data_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o,
    output logic [PTR_W-1:0]  dptr_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              cy;
        logic              ac;
        logic              ov;
        logic [PTR_W-1:0]  dptr;
        logic              done;
        logic              illegal;
        logic [1:0]        len;
        logic [1:0]        cyc;
        logic              wb_en;
        logic              wb_mem;
        logic [DATA_W-1:0] wb_addr;
        logic [DATA_W-1:0] wb_data;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;

    logic [DATA_W-1:0] opnd;
    logic              is_step;
    logic              alu_sub;
    logic              alu_cin;
    logic [DATA_W-1:0] alu_a, alu_b, alu_res;
    logic              alu_cy, alu_ac, alu_ov;
    logic [PTR_W-1:0]  dptr_next;

    arith_decode u_dec (
        .opcode (opcode_i),
        .dec    (dec)
    );

    // Operand read addresses
    assign rf_addr_o  = (dec.src == S_IND) ? RF_AW'(opcode_i[0]) : opcode_i[RF_AW-1:0];
    assign mem_addr_o = (dec.src == S_DIR) ? imm_i : rf_data_i;

    always_comb begin
        unique case (dec.src)
            S_REG:         opnd = rf_data_i;
            S_DIR, S_IND:  opnd = mem_data_i;
            S_IMM:         opnd = imm_i;
            S_ACC:         opnd = st_q.acc;
            default:       opnd = '0;
        endcase
    end

    assign is_step = (dec.kind == K_INC) || (dec.kind == K_DEC);
    assign alu_sub = (dec.kind == K_SUBB) || (dec.kind == K_DEC);
    assign alu_cin = ((dec.kind == K_ADDC) || (dec.kind == K_SUBB)) ? st_q.cy : 1'b0;
    assign alu_a   = is_step ? opnd : st_q.acc;
    assign alu_b   = is_step ? ONE  : opnd;

    arith_alu #(.DATA_W(DATA_W)) u_alu (
        .sub (alu_sub),
        .a   (alu_a),
        .b   (alu_b),
        .cin (alu_cin),
        .res (alu_res),
        .cy  (alu_cy),
        .ac  (alu_ac),
        .ov  (alu_ov)
    );

    ptr_incr #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ptr (
        .ptr_in  (st_q.dptr),
        .ptr_out (dptr_next)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = issue_i;
        st_d.illegal = 1'b0;
        st_d.len     = 2'd0;
        st_d.cyc     = 2'd0;
        st_d.wb_en   = 1'b0;
        st_d.wb_mem  = 1'b0;
        st_d.wb_addr = '0;
        st_d.wb_data = '0;
        if (issue_i) begin
            st_d.len = dec.len;
            st_d.cyc = dec.cyc;
            unique case (dec.kind)
                K_ADD, K_ADDC, K_SUBB: begin
                    st_d.acc = alu_res;
                    st_d.cy  = alu_cy;
                    st_d.ac  = alu_ac;
                    st_d.ov  = alu_ov;
                end
                K_INC, K_DEC: begin
                    if (dec.src == S_ACC) begin
                        st_d.acc = alu_res;
                    end else begin
                        st_d.wb_en   = 1'b1;
                        st_d.wb_data = alu_res;
                        st_d.wb_mem  = (dec.src != S_REG);
                        st_d.wb_addr = (dec.src == S_REG) ? DATA_W'(opcode_i[RF_AW-1:0])
                                                          : mem_addr_o;
                    end
                end
                K_PTRINC: st_d.dptr = dptr_next;
                default: begin
                    st_d.illegal = 1'b1;
                    st_d.len     = 2'd1;
                    st_d.cyc     = 2'd1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o      = st_q.done;
    assign illegal_o   = st_q.illegal;
    assign len_o       = st_q.len;
    assign cyc_o       = st_q.cyc;
    assign wb_en_o     = st_q.wb_en;
    assign wb_to_mem_o = st_q.wb_mem;
    assign wb_addr_o   = st_q.wb_addr;
    assign wb_data_o   = st_q.wb_data;
    assign acc_o       = st_q.acc;
    assign cy_o        = st_q.cy;
    assign ac_o        = st_q.ac;
    assign ov_o        = st_q.ov;
    assign dptr_o      = st_q.dptr;

    // Assertions
    AST_STEP_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && is_step |=> $stable({cy_o, ac_o, ov_o})); // R5

    AST_MEM_STEP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && is_step && (dec.src != S_ACC) |=> $stable(acc_o) && wb_en_o); // R5

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && (dec.kind == K_PTRINC) |=> dptr_o == PTR_W'($past(dptr_o) + 1'b1)); // R6

    AST_PTR_ONLY_ON_A3: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_i && opcode_i == 8'hA3) |=> $stable(dptr_o)); // R6

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !wb_en_o && done_o && len_o == 2'd1 && cyc_o == 2'd1); // R9

    AST_ILLEGAL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && !dec.legal |=> $stable({acc_o, cy_o, ac_o, ov_o, dptr_o})); // R9

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (len_o == 2'd1 || len_o == 2'd2)); // R7

    AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cyc_o == 2'd1 || cyc_o == 2'd2)); // R8

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> !wb_en_o && !illegal_o && len_o == 2'd0 && cyc_o == 2'd0); // R12

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> $stable({acc_o, cy_o, ac_o, ov_o, dptr_o})); // R12
endmodule

// File: tb/arith_exec_unit_bench.sv
module arith_exec_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  imm = 8'h00;
    logic [2:0]  rf_addr;
    logic [7:0]  rf_data;
    logic [7:0]  mem_addr;
    logic [7:0]  mem_data;
    logic        done, illegal, wb_en, wb_mem, cy, ac, ov;
    logic [1:0]  len, cyc;
    logic [7:0]  wb_addr, wb_data, acc;
    logic [15:0] dptr;

    logic [7:0] rf_m  [8];
    logic [7:0] mem_m [256];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Reference model state
    int m_acc = 0, m_cy = 0, m_ac = 0, m_ov = 0, m_dptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_data  = rf_m[rf_addr];
    assign mem_data = mem_m[mem_addr];

    arith_exec_unit u_arith_exec_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue),
        .opcode_i    (opcode),
        .imm_i       (imm),
        .rf_addr_o   (rf_addr),
        .rf_data_i   (rf_data),
        .mem_addr_o  (mem_addr),
        .mem_data_i  (mem_data),
        .done_o      (done),
        .illegal_o   (illegal),
        .len_o       (len),
        .cyc_o       (cyc),
        .wb_en_o     (wb_en),
        .wb_to_mem_o (wb_mem),
        .wb_addr_o   (wb_addr),
        .wb_data_o   (wb_data),
        .acc_o       (acc),
        .cy_o        (cy),
        .ac_o        (ac),
        .ov_o        (ov),
        .dptr_o      (dptr)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // kind: 0 add 1 addc 2 subb 3 inc 4 dec 5 ptr -1 illegal
    // src : 0 acc 1 reg 2 dir 3 ind 4 imm -1 none
    task automatic step(bit v, logic [7:0] op, logic [7:0] b2);
        int kind = -1, src = -1, hi = op[7:4], lo = op[3:0];
        int opd = 0, r = 0, c = 0, t = 0, full = 0;
        int e_ill = 0, e_len = 0, e_cyc = 0, e_wb = 0, e_wbm = 0, e_wa = 0, e_wd = 0;
        int n_acc = m_acc, n_cy = m_cy, n_ac = m_ac, n_ov = m_ov, n_dp = m_dptr;
        string rq;

        if (op == 8'hA3) kind = 5;
        else if (hi == 2) kind = 0;
        else if (hi == 3) kind = 1;
        else if (hi == 9) kind = 2;
        else if (hi == 0) kind = 3;
        else if (hi == 1) kind = 4;
        if (kind >= 0 && kind <= 4) begin
            if (lo >= 8) src = 1;
            else if (lo == 5) src = 2;
            else if (lo == 6 || lo == 7) src = 3;
            else if (lo == 4) src = (kind <= 2) ? 4 : 0;
            else kind = -1;
        end

        case (src)
            0: opd = m_acc;
            1: opd = rf_m[lo & 7];
            2: opd = mem_m[b2];
            3: opd = mem_m[rf_m[op[0]]];
            4: opd = b2;
            default: opd = 0;
        endcase

        if (v) begin
            if (kind < 0) begin
                e_ill = 1; e_len = 1; e_cyc = 1;
            end else begin
                e_len = (src == 2 || src == 4) ? 2 : 1;
                e_cyc = (src == 2 || src == 3 || src == 4) ? 2 : 1;
            end
            if (kind == 0 || kind == 1) begin
                c = (kind == 1) ? m_cy : 0;
                full = m_acc + opd + c;
                n_acc = full & 255;
                n_cy = (full > 255);
                n_ac = (((m_acc & 15) + (opd & 15) + c) > 15);
                t = sgn(m_acc) + sgn(opd) + c;
                n_ov = (t > 127 || t < -128);
            end else if (kind == 2) begin
                c = m_cy;
                full = m_acc - opd - c;
                n_acc = (full + 512) % 256;
                n_cy = (full < 0);
                n_ac = (((m_acc & 15) - (opd & 15) - c) < 0);
                t = sgn(m_acc) - sgn(opd) - c;
                n_ov = (t > 127 || t < -128);
            end else if (kind == 3 || kind == 4) begin
                r = (kind == 3) ? (opd + 1) & 255 : (opd + 255) & 255;
                if (src == 0) n_acc = r;
                else begin
                    e_wb = 1; e_wd = r;
                    e_wbm = (src != 1);
                    e_wa = (src == 1) ? (lo & 7) : (src == 2) ? b2 : rf_m[op[0]];
                end
            end else if (kind == 5) begin
                n_dp = (m_dptr + 1) & 16'hFFFF;
            end
        end

        case (kind)
            0: rq = "R1";
            1: rq = "R2";
            2: rq = "R3";
            3, 4: rq = "R5";
            5: rq = "R6";
            default: rq = "R9";
        endcase
        if (!v) rq = "R12";

        @(negedge clk);
        issue = v; opcode = op; imm = b2;
        #1;
        if (v && src == 1) chk("R10", "rf_addr reg", rf_addr, lo & 7);
        if (v && src == 3) begin
            chk("R10", "rf_addr ind", rf_addr, op[0]);
            chk("R10", "mem_addr ind", mem_addr, rf_m[op[0]]);
        end
        if (v && src == 2) chk("R10", "mem_addr dir", mem_addr, b2);

        @(posedge clk);
        #1;
        chk(v ? "R9" : "R12", "done", done, v);
        chk(v ? "R9" : "R12", "illegal", illegal, e_ill);
        chk(v ? "R7" : "R12", "len", len, e_len);
        chk(v ? "R8" : "R12", "cyc", cyc, e_cyc);
        chk(rq, "wb_en", wb_en, e_wb);
        chk(rq, "wb_to_mem", wb_mem, e_wbm);
        chk(rq, "wb_addr", wb_addr, e_wa);
        chk(rq, "wb_data", wb_data, e_wd);
        chk(rq, "acc", acc, n_acc);
        chk((kind <= 2 && kind >= 0 && v) ? "R4" : rq, "cy", cy, n_cy);
        chk((kind <= 2 && kind >= 0 && v) ? "R4" : rq, "ac", ac, n_ac);
        chk((kind <= 2 && kind >= 0 && v) ? "R4" : rq, "ov", ov, n_ov);
        chk(rq, "dptr", dptr, n_dp);

        m_acc = n_acc; m_cy = n_cy; m_ac = n_ac; m_ov = n_ov; m_dptr = n_dp;
        if (e_wb == 1) begin
            if (e_wbm == 1) mem_m[e_wa] = e_wd[7:0];
            else rf_m[e_wa] = e_wd[7:0];
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) rf_m[i] = 8'(8'h10 * i + 3);
        rf_m[0] = 8'h40;
        rf_m[1] = 8'hFE;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'(i) ^ 8'h5A;
        mem_m[8'h30] = 8'hFF;
        mem_m[8'h31] = 8'h00;

        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", "acc", acc, 0);
        chk("R11", "flags", {cy, ac, ov}, 0);
        chk("R11", "dptr", dptr, 0);
        chk("R11", "done", done, 0);
        chk("R11", "wb_en", wb_en, 0);
        chk("R11", "len", len, 0);
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 8'h24, 8'h11);          // R12 idle
        // R1 forms
        step(1, 8'h24, 8'h3A);
        step(1, 8'h24, 8'hC6);          // carry, half carry
        step(1, 8'h24, 8'h7F);
        step(1, 8'h24, 8'h01);          // 7F+... signed overflow path
        for (int n = 8'h28; n <= 8'h2F; n++) step(1, 8'(n), 8'h00);
        step(1, 8'h25, 8'h30);
        step(1, 8'h26, 8'h00);
        step(1, 8'h27, 8'h00);
        // R2 forms
        step(1, 8'h24, 8'hFF);
        step(1, 8'h34, 8'h00);
        for (int n = 8'h38; n <= 8'h3F; n += 3) step(1, 8'(n), 8'h00);
        step(1, 8'h35, 8'h31);
        step(1, 8'h36, 8'h00);
        step(1, 8'h37, 8'h00);
        // R3 forms
        step(1, 8'h94, 8'h80);
        step(1, 8'h94, 8'h01);
        step(1, 8'h98, 8'h00);
        step(1, 8'h9F, 8'h00);
        step(1, 8'h95, 8'h30);
        step(1, 8'h96, 8'h00);
        step(1, 8'h97, 8'h00);
        step(1, 8'h94, 8'hFF);
        // R5 forms
        step(1, 8'h04, 8'h00);
        step(1, 8'h14, 8'h00);
        step(1, 8'h14, 8'h00);
        step(1, 8'h08, 8'h00);
        step(1, 8'h0F, 8'h00);
        step(1, 8'h18, 8'h00);
        step(1, 8'h05, 8'h30);          // FF -> 00
        step(1, 8'h15, 8'h31);          // 00 -> FF
        step(1, 8'h06, 8'h00);
        step(1, 8'h07, 8'h00);
        step(1, 8'h16, 8'h00);
        step(1, 8'h17, 8'h00);
        // R6
        step(1, 8'hA3, 8'h00);
        step(0, 8'hA3, 8'h00);
        step(1, 8'hA3, 8'h00);
        // R9 illegal
        step(1, 8'h00, 8'h00);
        step(1, 8'h01, 8'h00);
        step(1, 8'h03, 8'h00);
        step(1, 8'h13, 8'h00);
        step(1, 8'hA4, 8'h00);
        step(1, 8'h84, 8'h00);
        step(1, 8'hFF, 8'h00);
        step(1, 8'h92, 8'h00);
        // random mix
        for (int k = 0; k < 600; k++) step(1'($urandom), 8'($urandom), 8'($urandom));
        // R6 wrap of the data pointer
        for (int k = 0; k < 65540; k++) step(1, 8'hA3, 8'h00);
        step(0, 8'h00, 8'h00);
        finish_run();
    end
endmodule